// File: doc/BRIEF.md
# Dual-Field Word Multiply-Accumulate Core

This block is the arithmetic heart of a word-serial Montgomery multiplier. It takes two operand words and forms their product. The product is either an ordinary integer product, used for prime-field work, or a carry-less polynomial product, used for binary-extension-field work. The block adds that product into a three-word accumulator. A sequencer outside the block walks the operand words, decides which partial products to fold in, and moves the accumulator down one word at the end of each column.

One field-select pin decides the arithmetic. With it low, every adder in the multiplier tree and in the accumulator propagates carries. With it high, all carries are forced to zero, so each sum is a bitwise XOR. For squaring, a doubling pin shifts the product left by one place before it is added. This lets each symmetric pair of cross products be handled by a single multiplication.

Only control pins and data words cross the edge; there is no handshake. One operation is accepted every clock. The low accumulator word is visible at all times, so the sequencer can form the reduction multiplier word from it. The word dropped by the most recent right shift is held on a separate output, where it can be written to result storage.

Top module: `dfmac_core`

## Requirements
- R1: After reset, `v0_o` and `shout_o` are zero and the accumulator holds zero.
- R2: With `field_i`=0 and `ld_i`=1, the accumulator (3·WORD bits, `v0_o` being bits WORD-1:0) becomes its old value plus `a_i`·`b_i`, modulo 2^(3·WORD).
- R3: With `field_i`=1 and `ld_i`=1, the accumulator becomes its old value XOR the carry-less product of `a_i` and `b_i`; no carry crosses any bit position.
- R4: With `dbl_i`=1, the product is shifted left by one bit before it is accumulated, in either field.
- R5: In the binary field, the product's bit 2·WORD-1 is always zero, and so is the bit above it before doubling.
- R6: With `shr_i`=1 and `ld_i`=0, the accumulator moves right by one word and zeros enter the top word. The dropped low word appears on `shout_o` after that clock edge.
- R7: With `ld_i`=1 and `shr_i`=1, the accumulator takes the new sum shifted right by one word, and `shout_o` takes the sum's low word.
- R8: `clr_i`=1 zeroes the accumulator and overrides `ld_i` and `shr_i`; `shout_o` is left unchanged in that cycle.
- R9: With `ld_i`, `shr_i` and `clr_i` all low, the accumulator and `shout_o` hold their values.
- R10: `v0_o` always shows the accumulator's low word, one register stage after the controlling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_i | input | 1 | 0: integer arithmetic, 1: carry-less arithmetic |
| dbl_i | input | 1 | Double the product before accumulating |
| ld_i | input | 1 | Load the adder sum into the accumulator |
| shr_i | input | 1 | Shift the accumulator right by one word |
| clr_i | input | 1 | Synchronous clear of the accumulator |
| a_i | input | WORD | First operand word |
| b_i | input | WORD | Second operand word |
| v0_o | output | WORD | Low accumulator word |
| shout_o | output | WORD | Word dropped by the latest right shift |

## Verification
The bench instantiates a 4-bit word and sweeps every operand pair through both fields, with and without doubling. A tree that leaked a carry in binary mode, or dropped one in integer mode, would therefore show up in some product. Long runs of doubled maximal products push carries into the top word and past its end. A design that truncated the doubled product, or failed to wrap at the accumulator width, would return a wrong top word. Directed sequences then combine load with shift, and clear with load and shift, in the same cycle. An implementation that shifted before adding, or that let a clear still move a word onto the shift output, would present the wrong `shout_o` or a nonzero `v0_o`. Idle cycles are checked for drift of either output.

// File: rtl/dfmac_pkg.sv
package dfmac_pkg;

  typedef enum logic {
    FLD_PRIME  = 1'b0,
    FLD_BINARY = 1'b1
  } field_e;

  typedef struct packed {
    logic clr;
    logic ld;
    logic shr;
  } acc_op_t;

endpackage

// File: rtl/dfmac_adder.sv
module dfmac_adder #(
  parameter int WIDTH = 96
) (
  input  logic             field_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] z_o
);
  logic [WIDTH:0] cy;

  assign cy[0] = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    logic maj;
    assign z_o[k]  = x_i[k] ^ y_i[k] ^ cy[k];
    assign maj     = (x_i[k] & y_i[k]) | (x_i[k] & cy[k]) | (y_i[k] & cy[k]);
    assign cy[k+1] = field_i ? 1'b0 : maj;
  end

endmodule

// File: rtl/dfmac_mult.sv
module dfmac_mult #(
  parameter int WORD = 32
) (
  input  logic              field_i,
  input  logic [WORD-1:0]   a_i,
  input  logic [WORD-1:0]   b_i,
  output logic [2*WORD:0]   prod_o
);
  localparam int PW = 2 * WORD;

  logic [PW-1:0] pp    [WORD];
  logic [PW-1:0] s_vec [WORD];
  logic [PW-1:0] c_vec [WORD];

  for (genvar k = 0; k < WORD; k++) begin : g_pp
    assign pp[k] = b_i[k] ? ({{WORD{1'b0}}, a_i} << k) : '0;
  end

  assign s_vec[0] = pp[0];
  assign c_vec[0] = '0;

  for (genvar k = 1; k < WORD; k++) begin : g_csa
    logic [PW-1:0] maj;
    assign s_vec[k] = s_vec[k-1] ^ c_vec[k-1] ^ pp[k];
    assign maj      = (s_vec[k-1] & c_vec[k-1]) | (s_vec[k-1] & pp[k])
                    | (c_vec[k-1] & pp[k]);
    assign c_vec[k] = field_i ? '0 : {maj[PW-2:0], 1'b0};
  end

  dfmac_adder #(.WIDTH(PW + 1)) u_cpa (
    .field_i (field_i),
    .x_i     ({1'b0, s_vec[WORD-1]}),
    .y_i     ({1'b0, c_vec[WORD-1]}),
    .z_o     (prod_o)
  );

endmodule

// File: rtl/dfmac_core.sv
module dfmac_core
  import dfmac_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_i,
  input  logic            dbl_i,
  input  logic            ld_i,
  input  logic            shr_i,
  input  logic            clr_i,
  input  logic [WORD-1:0] a_i,
  input  logic [WORD-1:0] b_i,
  output logic [WORD-1:0] v0_o,
  output logic [WORD-1:0] shout_o
);
  localparam int PW = 2 * WORD;
  localparam int AW = 3 * WORD;

  field_e         fld;
  acc_op_t        op;
  logic [PW:0]    prod_w;
  logic [PW:0]    term_w;
  logic [AW-1:0]  term_ext;
  logic [AW-1:0]  sum_w;
  logic [WORD-1:0] v_q [3];
  logic [AW-1:0]  acc_w;
  logic [AW-1:0]  acc_nx;
  logic [WORD-1:0] shout_nx;

  assign fld = field_e'(field_i);
  assign op  = '{clr: clr_i, ld: ld_i, shr: shr_i};

  dfmac_mult #(.WORD(WORD)) u_mult (
    .field_i (fld == FLD_BINARY),
    .a_i     (a_i),
    .b_i     (b_i),
    .prod_o  (prod_w)
  );

  assign term_w   = dbl_i ? {prod_w[PW-1:0], 1'b0} : prod_w;
  assign term_ext = {{(AW-PW-1){1'b0}}, term_w};
  assign acc_w    = {v_q[2], v_q[1], v_q[0]};

  dfmac_adder #(.WIDTH(AW)) u_acc_add (
    .field_i (fld == FLD_BINARY),
    .x_i     (acc_w),
    .y_i     (term_ext),
    .z_o     (sum_w)
  );

  always_comb begin
    acc_nx   = acc_w;
    shout_nx = shout_o;
    if (op.clr) begin
      acc_nx = '0;
    end else if (op.ld && op.shr) begin
      acc_nx   = sum_w >> WORD;
      shout_nx = sum_w[WORD-1:0];
    end else if (op.ld) begin
      acc_nx = sum_w;
    end else if (op.shr) begin
      acc_nx   = acc_w >> WORD;
      shout_nx = acc_w[WORD-1:0];
    end
  end

  for (genvar w = 0; w < 3; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[w] <= '0;
      else        v_q[w] <= acc_nx[w*WORD +: WORD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shout_o <= '0;
    else        shout_o <= shout_nx;
  end

  assign v0_o = v_q[0];

endmodule

// File: rtl/dfmac_core_chk.sv
module dfmac_core_chk #(
  parameter int WORD = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            field_i,
  input logic            ld_i,
  input logic            shr_i,
  input logic            clr_i,
  input logic [WORD-1:0] v0_o,
  input logic [WORD-1:0] shout_o,
  input logic [2*WORD:0] prod_w,
  input logic [3*WORD-1:0] sum_w
);
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (v0_o == '0)); // R8

  AST_CLR_KEEPS_SHOUT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> $stable(shout_o)); // R8

  AST_SHIFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_i && !ld_i && !clr_i) |=> (shout_o == $past(v0_o))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !shr_i && !clr_i) |=> ($stable(v0_o) && $stable(shout_o))); // R9

  AST_BIN_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    field_i |-> (prod_w[2*WORD:2*WORD-1] == 2'b00)); // R5

  AST_LDSHR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && shr_i && !clr_i) |=> (shout_o == $past(sum_w[WORD-1:0]))); // R7

endmodule

bind dfmac_core dfmac_core_chk #(.WORD(WORD)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .field_i (field_i),
  .ld_i    (ld_i),
  .shr_i   (shr_i),
  .clr_i   (clr_i),
  .v0_o    (v0_o),
  .shout_o (shout_o),
  .prod_w  (prod_w),
  .sum_w   (sum_w)
);

// File: tb/dfmac_core_tb_top.sv
module dfmac_core_tb_top;
  localparam int W  = 4;
  localparam int AW = 3 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_i = 1'b0, dbl_i = 1'b0, ld_i = 1'b0, shr_i = 1'b0, clr_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] v0_o, shout_o;

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;
  logic [AW-1:0] macc = '0;
  logic [W-1:0]  mshout = '0;

  always #5 clk = ~clk;

  dfmac_core #(.WORD(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .field_i(field_i), .dbl_i(dbl_i),
    .ld_i(ld_i), .shr_i(shr_i), .clr_i(clr_i), .a_i(a_i), .b_i(b_i),
    .v0_o(v0_o), .shout_o(shout_o)
  );

  task automatic check(input logic ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addend(input logic f, input logic d,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
    logic [AW-1:0] r;
    r = '0;
    if (!f) begin
      r = AW'(a) * AW'(b);
    end else begin
      for (int k = 0; k < W; k++) if (b[k]) r = r ^ (AW'(a) << k);
    end
    return d ? (r << 1) : r;
  endfunction

  function automatic logic [AW-1:0] combine(input logic f, input logic [AW-1:0] x,
                                            input logic [AW-1:0] y);
    return f ? (x ^ y) : (x + y);
  endfunction

  task automatic drive(input logic f, input logic d, input logic l, input logic s,
                       input logic c, input logic [W-1:0] a, input logic [W-1:0] b);
    field_i = f; dbl_i = d; ld_i = l; shr_i = s; clr_i = c; a_i = a; b_i = b;
    @(negedge clk);
    field_i = 1'b0; dbl_i = 1'b0; ld_i = 1'b0; shr_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic load_op(input logic f, input logic d, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    drive(f, d, 1'b1, 1'b0, 1'b0, a, b);
    macc = combine(f, macc, addend(f, d, a, b));
  endtask

  task automatic read_acc(input string req);
    logic [AW-1:0] got;
    check(v0_o == macc[W-1:0], "R10", AW'(v0_o), AW'(macc[W-1:0]));
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
      got[k*W +: W] = shout_o;
    end
    check(got == macc, req, got, macc);
    macc = '0;
    mshout = got[AW-1 -: W];
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [AW-1:0] s;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(v0_o == '0, "R1", AW'(v0_o), '0);
    check(shout_o == '0, "R1", AW'(shout_o), '0);
    rst_n = 1'b1;
    @(negedge clk);
    read_acc("R1");

    // R2 R3 R4 R5: exhaustive sweep of single products
    for (int f = 0; f < 2; f++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++) begin
            load_op(f[0], d[0], W'(a), W'(b));
            read_acc(f == 0 ? (d == 0 ? "R2" : "R4") : (d == 0 ? "R3" : "R5"));
          end

    // R2 R4: doubled maximal products carry into the top word and wrap
    for (int k = 0; k < 20; k++) load_op(1'b0, 1'b1, '1, '1);
    read_acc("R4");

    // R3: equal products cancel without carries
    load_op(1'b1, 1'b0, 4'hb, 4'h7);
    load_op(1'b1, 1'b0, 4'hb, 4'h7);
    read_acc("R3");

    // R7: load and shift in one cycle
    load_op(1'b0, 1'b0, 4'hf, 4'he);
    s = combine(1'b0, macc, addend(1'b0, 1'b1, 4'hd, 4'hb));
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hd, 4'hb);
    macc = s >> W;
    check(shout_o == s[W-1:0], "R7", AW'(shout_o), AW'(s[W-1:0]));
    read_acc("R7");

    // R6: a shift of a nonzero value
    load_op(1'b0, 1'b0, 4'h9, 4'h9);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
    check(shout_o == macc[W-1:0], "R6", AW'(shout_o), AW'(macc[W-1:0]));
    macc = macc >> W;
    read_acc("R6");

    // R8: clear beats load and shift, shift output untouched
    load_op(1'b0, 1'b0, 4'h6, 4'h5);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
    mshout = shout_o;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hf, 4'hf);
    check(v0_o == '0, "R8", AW'(v0_o), '0);
    check(shout_o == mshout, "R8", AW'(shout_o), AW'(mshout));
    macc = '0;
    read_acc("R8");

    // R9: idle cycles hold
    load_op(1'b0, 1'b0, 4'h7, 4'h3);
    mshout = shout_o;
    for (int k = 0; k < 4; k++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hf, 4'hf);
    check(shout_o == mshout, "R9", AW'(shout_o), AW'(mshout));
    read_acc("R9");

    finished = 1'b1;
    summary();
  end

endmodule